// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This controller moves a set of registers to or from word-addressed memory, one word per cycle. A one-cycle start pulse gives the direction (load or store), the index of the base register, a 16-bit register mask, an addressing mode and a writeback flag. The sequencer first reads the base value through the register-file read port. It then visits the selected registers from the lowest index to the highest. For each one it raises a memory request, and the request completes in any cycle where `mem_ready` is high.

A paired form, selected by `dual`, moves the two registers 2k and 2k+1. Their addresses are the base plus a sign-extended 12-bit offset, and that address plus 4. After the final transfer, one cycle asserts `done`. In that same cycle the updated base is written back when writeback was requested. The register file is expected to answer reads combinationally. Memory read data must be valid in the cycle where the request and `mem_ready` are both high.

Top module: `ldm_stm_seq`

## Requirements
- R1: Selected registers are transferred in strictly ascending register index, whatever the mask pattern.
- R2: On a load, each completed request writes `mem_rdata` into the register being visited, in the same cycle as the request.
- R3: On a store, `mem_wdata` carries the visited register's contents, `mem_we` is 1, and the register file is not written during transfers.
- R4: `mode` 2'b00 (increment-after): the first address is the base, and each later transfer adds 4.
- R5: `mode` 2'b01 (increment-before) starts at base+4. `mode` 2'b10 (decrement-after) starts at base-4*N+4. `mode` 2'b11 (decrement-before) starts at base-4*N. N is the number of mask bits set, and addresses rise by 4 in register order.
- R6: When `wback` is 1, the base register receives base+4*N (`mode[1]`=0) or base-4*N (`mode[1]`=1) in the `done` cycle. When `wback` is 0, the base register is left alone.
- R7: With `dual`=1, registers 2*`pair_sel` and 2*`pair_sel`+1 use addresses base+offset and base+offset+4, and no writeback happens.
- R8: While `mem_ready` is low, the request, address, direction and register index hold steady.
- R9: An all-zero mask makes no memory request, leaves the base unchanged, and raises `done` in the cycle after start.
- R10: `done` is high for exactly one cycle. With `mem_ready` held high it comes N+1 cycles after the start edge.
- R11: A start pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| is_load | input | 1 | 1 = memory to registers, 0 = registers to memory |
| base_idx | input | 4 | Base register index |
| reg_mask | input | 16 | Register selection mask |
| mode | input | 2 | Address stepping mode |
| wback | input | 1 | Write updated base back |
| dual | input | 1 | Paired form with offset |
| pair_sel | input | 3 | Register pair for paired form |
| offset | input | 12 | Signed offset for paired form |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ready | input | 1 | Memory accepts request this cycle |
| rf_raddr | output | 4 | Register file read index |
| rf_rdata | input | 32 | Register file read data |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 4 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| done | output | 1 | Operation complete pulse |

## Verification
Each memory transfer is due in the cycle where `mem_req` and `mem_ready` are both high. The first transfer can come no earlier than the cycle after the start edge. Load data lands in the register file at the end of that same cycle. `done`, and any base writeback, come one cycle after the last completed transfer. That makes N+1 cycles after start when `mem_ready` stays high, and one cycle for an empty mask. The bench queues every expected transfer when it issues start. It compares them at the falling edge of each completing cycle, counts cycles to `done` and checks that count whenever no stalls were injected, and reads the base register back one cycle after `done`.

// File: rtl/ldm_stm_seq.sv
module ldm_stm_seq #(
  parameter int DW   = 32,
  parameter int OFFW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            is_load,
  input  logic [3:0]      base_idx,
  input  logic [15:0]     reg_mask,
  input  logic [1:0]      mode,
  input  logic            wback,
  input  logic            dual,
  input  logic [2:0]      pair_sel,
  input  logic [OFFW-1:0] offset,
  output logic            busy,
  output logic            mem_req,
  output logic            mem_we,
  output logic [DW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ready,
  output logic [3:0]      rf_raddr,
  input  logic [DW-1:0]   rf_rdata,
  output logic            rf_we,
  output logic [3:0]      rf_waddr,
  output logic [DW-1:0]   rf_wdata,
  output logic            done
);
  localparam logic [DW-1:0] STEP = DW'(4);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_FIN} st_t;
  st_t st;

  logic [15:0]   pend;
  logic [DW-1:0] addr_q, nb_q;
  logic [3:0]    bidx_q, cur;
  logic          load_q, wb_q;

  wire [15:0]   pair_mask = 16'b11 << {pair_sel, 1'b0};
  wire [15:0]   eff_mask  = dual ? pair_mask : reg_mask;
  wire [4:0]    cnt       = 5'($countones(reg_mask));
  wire [DW-1:0] span      = DW'(cnt) << 2;
  wire [DW-1:0] soff      = {{(DW-OFFW){offset[OFFW-1]}}, offset};
  wire [DW-1:0] base_v    = rf_rdata;
  wire [DW-1:0] low_v     = base_v - span;
  wire          last      = (pend & (pend - 16'd1)) == 16'd0;
  wire          xfer      = (st == S_XFER) && mem_ready;

  logic [DW-1:0] first_a;
  always_comb begin
    if (dual) first_a = base_v + soff;
    else begin
      case (mode)
        2'b00:   first_a = base_v;
        2'b01:   first_a = base_v + STEP;
        2'b10:   first_a = low_v + STEP;
        default: first_a = low_v;
      endcase
    end
  end

  always_comb begin
    cur = 4'd0;
    for (int i = 15; i >= 0; i--)
      if (pend[i]) cur = 4'(i);
  end

  assign busy      = st != S_IDLE;
  assign done      = st == S_FIN;
  assign mem_req   = st == S_XFER;
  assign mem_we    = !load_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = rf_rdata;
  assign rf_raddr  = (st == S_IDLE) ? base_idx : cur;
  assign rf_we     = (xfer && load_q) || (done && wb_q);
  assign rf_waddr  = done ? bidx_q : cur;
  assign rf_wdata  = done ? nb_q : mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      pend   <= '0;
      addr_q <= '0;
      nb_q   <= '0;
      bidx_q <= '0;
      load_q <= 1'b0;
      wb_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          pend   <= eff_mask;
          addr_q <= first_a;
          nb_q   <= mode[1] ? low_v : base_v + span;
          bidx_q <= base_idx;
          load_q <= is_load;
          wb_q   <= wback && !dual && (reg_mask != 16'd0);
          st     <= (eff_mask == 16'd0) ? S_FIN : S_XFER;
        end
        S_XFER: if (mem_ready) begin
          pend   <= pend & ~(16'd1 << cur);
          addr_q <= addr_q + STEP;
          if (last) st <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ldm_stm_seq_chk.sv
module ldm_stm_seq_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [DW-1:0] mem_addr,
  input logic [3:0]    rf_raddr,
  input logic          rf_we,
  input logic          done
);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(rf_raddr));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ready |=> !mem_req || (mem_addr == $past(mem_addr) + DW'(4)));

  // R1
  reg_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ready |=> !mem_req || (rf_raddr > $past(rf_raddr)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

  // R3
  store_no_rf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !rf_we);
endmodule

bind ldm_stm_seq ldm_stm_seq_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ready(mem_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .rf_raddr(rf_raddr),
  .rf_we(rf_we), .done(done)
);

// File: tb/ldm_stm_seq_tb_top.sv
module ldm_stm_seq_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, is_load = 0, wback = 0, dual = 0;
  logic [3:0] base_idx = 0;
  logic [15:0] reg_mask = 0;
  logic [1:0] mode = 0;
  logic [2:0] pair_sel = 0;
  logic [11:0] offset = 0;
  logic busy, mem_req, mem_we, mem_ready, rf_we, done;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rdata, rf_wdata;
  logic [3:0] rf_raddr, rf_waddr;
  logic stall_en = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [31:0] rf [16];
  logic [31:0] mem [256];

  int nchk = 0, nerr = 0;

  typedef struct {
    logic [31:0] addr;
    logic        we;
    logic [3:0]  idx;
    logic [31:0] data;
    int          req;
  } item_t;
  item_t sbq[$];

  always #(CLK_P/2) clk = ~clk;

  ldm_stm_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .is_load(is_load),
    .base_idx(base_idx), .reg_mask(reg_mask), .mode(mode), .wback(wback),
    .dual(dual), .pair_sel(pair_sel), .offset(offset), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .done(done)
  );

  assign rf_rdata  = rf[rf_raddr];
  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) rf[i] <= 32'h0000_0200 + 32'(i) * 32'h44;
      for (int i = 0; i < 256; i++) mem[i] <= 32'hC0DE_0000 + 32'(i);
    end else begin
      if (rf_we) rf[rf_waddr] <= rf_wdata;
      if (mem_req && mem_ready && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    end
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready <= !stall_en || lfsr[0];
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_ready) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R11 unexpected transfer", mem_addr, 32'h0);
      end else begin
        item_t it;
        it = sbq.pop_front();
        chk(mem_addr == it.addr, $sformatf("R%0d address", it.req), mem_addr, it.addr);
        chk(rf_raddr == it.idx, "R1 register order", 32'(rf_raddr), 32'(it.idx));
        chk(mem_we == it.we, "R3 direction", 32'(mem_we), 32'(it.we));
        if (it.we) chk(mem_wdata == it.data, "R3 store data", mem_wdata, it.data);
        else chk(rf_we && rf_waddr == it.idx && rf_wdata == it.data, "R2 load write",
                 rf_wdata, it.data);
      end
    end
  end

  task automatic run_op(input logic ld, input logic [3:0] b, input logic [15:0] m,
                        input logic [1:0] md, input logic wb, input logic dl,
                        input logic [2:0] ps, input logic [11:0] off,
                        input logic stl, input logic poke);
    logic [15:0] sel;
    logic [31:0] base, a, exp_base;
    int n, k, rq;
    @(negedge clk);
    while (busy) @(negedge clk);
    base = rf[b];
    sel  = dl ? (16'b11 << {ps, 1'b0}) : m;
    n    = $countones(m);
    if (dl) begin a = base + {{20{off[11]}}, off}; rq = 7; end
    else begin
      case (md)
        2'b00: a = base;
        2'b01: a = base + 4;
        2'b10: a = base - 32'(4 * n) + 4;
        default: a = base - 32'(4 * n);
      endcase
      rq = (md == 2'b00) ? 4 : 5;
    end
    exp_base = base;
    for (int i = 0; i < 16; i++) begin
      if (sel[i]) begin
        item_t it;
        it.addr = a; it.we = !ld; it.idx = 4'(i); it.req = rq;
        it.data = ld ? mem[a[9:2]] : rf[i];
        if (ld && 4'(i) == b) exp_base = it.data;
        sbq.push_back(it);
        a += 4;
      end
    end
    if (wb && !dl && n != 0) exp_base = md[1] ? base - 32'(4 * n) : base + 32'(4 * n);
    stall_en = stl;
    is_load = ld; base_idx = b; reg_mask = m; mode = md; wback = wb;
    dual = dl; pair_sel = ps; offset = off; start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    k = 1;
    while (!done && k < 2000) begin
      @(negedge clk);
      k++;
      if (poke) begin
        start = (k == 2);
        reg_mask = 16'hFFFF;
      end
    end
    start = 0;
    chk(done == 1'b1, "R10 done reached", 32'(done), 32'd1);
    if (!stl) chk(k == n + 1 || (dl && k == 3), (sel == 0) ? "R9 empty done timing" : "R10 done timing",
                  32'(k), dl ? 32'd3 : 32'(n + 1));
    @(negedge clk);
    chk(done == 1'b0, "R10 single-cycle done", 32'(done), 32'd0);
    chk(sbq.size() == 0, "R1 all transfers seen", 32'(sbq.size()), 32'd0);
    chk(rf[b] == exp_base, dl ? "R7 no writeback" : (wb ? "R6 writeback" : "R6 base kept"),
        rf[b], exp_base);
    sbq.delete();
    stall_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", nchk, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk(!busy && !mem_req && !done, "R10 reset idle", {29'd0, busy, mem_req, done}, 32'd0);
    // R3 R4 R6: store increment-after with writeback
    run_op(0, 4'd13, 16'h0F0A, 2'b00, 1, 0, 3'd0, 12'd0, 0, 0);
    // R2 R4: load increment-after, base untouched
    run_op(1, 4'd2, 16'h8421, 2'b00, 0, 0, 3'd0, 12'd0, 0, 0);
    // R5: increment-before
    run_op(0, 4'd1, 16'h00F0, 2'b01, 1, 0, 3'd0, 12'd0, 0, 0);
    // R5: decrement-after load
    run_op(1, 4'd0, 16'h1234, 2'b10, 1, 0, 3'd0, 12'd0, 0, 0);
    // R5 R6: decrement-before full mask including base
    run_op(0, 4'd3, 16'hFFFF, 2'b11, 1, 0, 3'd0, 12'd0, 0, 0);
    // R9: empty mask
    run_op(1, 4'd6, 16'h0000, 2'b00, 1, 0, 3'd0, 12'd0, 0, 0);
    // R7: paired forms with negative and positive offsets
    run_op(0, 4'd1, 16'h0000, 2'b00, 0, 1, 3'd2, 12'hFF8, 0, 0);
    run_op(1, 4'd7, 16'h00FF, 2'b00, 1, 1, 3'd5, 12'd12, 0, 0);
    // R8: random stalls
    run_op(0, 4'd9, 16'h5555, 2'b00, 1, 0, 3'd0, 12'd0, 1, 0);
    run_op(1, 4'd14, 16'h3C03, 2'b11, 1, 0, 3'd0, 12'd0, 1, 0);
    // R11: start pulse while busy
    run_op(0, 4'd4, 16'h0E60, 2'b00, 1, 0, 3'd0, 12'd0, 0, 1);
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule